// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the program counter of a processor that uses fixed 32-bit instruction words and works out the address of the following instruction every cycle. It receives the instruction word now being executed and the two register operands the register file has already read for it. From these it picks one of four sources for the next PC. The first is the sequential address. The second is a PC-relative conditional branch on equal or not-equal operands. The third is an absolute jump that keeps the region bits of the PC. The fourth is a jump to the full value of a register.

The PC is a register. The link address, the link-write strobe and the misalignment flag are combinational outputs for the instruction in flight, so the surrounding pipeline can write the return address into register 31 in the same cycle. The register file, instruction memory, ALU and all non-control-flow instructions stay outside the block.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the PC loads the parameter `RESET_VEC`, which must be word-aligned (default 0x00000000).
- R2: An instruction whose opcode (bits [31:26]) is not 0, 2, 3, 4 or 5 advances the PC by 4.
- R3: The opcode sits in bits [31:26] and the signed 16-bit word offset in bits [15:0]. Opcode 4 (branch-if-equal) with `rs_val_i == rt_val_i` sets the next PC to PC + 4 + sign_extend(offset) × 4. For example, word 0x11200003 with equal operands moves the PC forward by 16.
- R4: Opcode 5 (branch-if-not-equal) with `rs_val_i != rt_val_i` sets the next PC to PC + 4 + sign_extend(offset) × 4.
- R5: A branch whose condition is false advances the PC by 4.
- R6: The branch offset covers the whole signed range. Offset 0x7FFF moves the PC by +0x20000, and offset 0x8000 moves it by −0x1FFFC relative to PC.
- R7: Opcode 2 (jump) sets the next PC to {PC[31:28], bits [25:0] of the word, 2'b00} and leaves `link_we_o` low.
- R8: Opcode 3 (jump-and-link) jumps as in R7, raises `link_we_o` in the same cycle and presents `link_o` = PC + 4 of that instruction. `link_we_o` is low for every other instruction, and `link_o` always equals PC + 4.
- R9: Opcode 0 with function field 0x08 in bits [5:0] (jump-register) loads all 32 bits of `rs_val_i` into the PC.
- R10: `jr_misalign_o` is high exactly when a jump-register is presented and `rs_val_i[1:0]` is non-zero. The unaligned value is still loaded unchanged.
- R11: Opcode 0 with any function field other than 0x08 advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word at the current PC |
| rs_val_i | input | XLEN | First source operand (compare operand and jump-register target) |
| rt_val_i | input | XLEN | Second source operand (compare operand) |
| pc_o | output | XLEN | Current program counter |
| link_o | output | XLEN | Return address, PC + 4 |
| link_we_o | output | 1 | Request to write `link_o` into register 31 |
| jr_misalign_o | output | 1 | Jump-register target not word-aligned |

## Verification
The assertions check every cycle that the PC moves as the presented instruction demands. They cover the reset load, the sequential advance for plain opcodes, taken and untaken branches of both kinds, the region-preserving jump splice, the full-width register jump and the link address. They also check that a raised misalignment flag is followed by an unaligned PC. The bench sweeps every opcode, every function field and a spread of branch offsets, including both extremes of the signed range, against an arithmetic model. That sweep is what shows that no stray opcode or function code is treated as control flow, that the exact worked encodings land where expected, and that the jump keeps a non-zero region nibble.

// File: rtl/pc_nxt_pkg.sv
package pc_nxt_pkg;

   localparam int INSTR_W = 32;
   localparam int OPC_W   = 6;
   localparam int FN_W    = 6;
   localparam int OFS_W   = 16;
   localparam int TGT_W   = 26;
   localparam int REGION_W = 4;

   localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
   localparam logic [OPC_W-1:0] OPC_JMP     = 6'd2;
   localparam logic [OPC_W-1:0] OPC_JAL     = 6'd3;
   localparam logic [OPC_W-1:0] OPC_BEQ     = 6'd4;
   localparam logic [OPC_W-1:0] OPC_BNE     = 6'd5;
   localparam logic [FN_W-1:0]  FN_JREG     = 6'h08;

   typedef enum logic [2:0] {
      FLOW_SEQ,
      FLOW_BEQ,
      FLOW_BNE,
      FLOW_JMP,
      FLOW_JAL,
      FLOW_JREG
   } flow_e;

endpackage

// File: rtl/pc_flow_decode.sv
module pc_flow_decode
   import pc_nxt_pkg::*;
(
   input  logic [OPC_W-1:0] opc_i,
   input  logic [FN_W-1:0]  fn_i,
   output flow_e            flow_o
);

   always_comb begin
      flow_o = FLOW_SEQ;
      case (opc_i)
         OPC_SPECIAL: if (fn_i == FN_JREG) flow_o = FLOW_JREG;
         OPC_JMP:     flow_o = FLOW_JMP;
         OPC_JAL:     flow_o = FLOW_JAL;
         OPC_BEQ:     flow_o = FLOW_BEQ;
         OPC_BNE:     flow_o = FLOW_BNE;
         default:     flow_o = FLOW_SEQ;
      endcase
   end

endmodule

// File: rtl/pc_branch_cmp.sv
module pc_branch_cmp #(
   parameter int XLEN      = 32,
   parameter int CMP_STYLE = 0
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic            eq_o
);

   generate
      if (CMP_STYLE == 0) begin : g_direct
         assign eq_o = (a_i == b_i);
      end else begin : g_xor_tree
         logic [XLEN-1:0] diff;
         assign diff = a_i ^ b_i;
         assign eq_o = ~|diff;
      end
   endgenerate

endmodule

// File: rtl/pc_target_gen.sv
module pc_target_gen
   import pc_nxt_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter int BR_ADD_STYLE = 0
) (
   input  logic [XLEN-1:0]  pc_i,
   input  logic [TGT_W-1:0] field_i,
   output logic [XLEN-1:0]  seq_o,
   output logic [XLEN-1:0]  br_o,
   output logic [XLEN-1:0]  jmp_o
);

   localparam int EXT_W = XLEN - OFS_W - 2;

   logic [OFS_W-1:0] ofs;
   logic [XLEN-1:0]  ofs_bytes;

   assign ofs       = field_i[OFS_W-1:0];
   assign ofs_bytes = {{EXT_W{ofs[OFS_W-1]}}, ofs, 2'b00};
   assign seq_o     = pc_i + XLEN'(4);
   assign jmp_o     = {pc_i[XLEN-1:XLEN-REGION_W], {(XLEN-REGION_W-TGT_W-2){1'b0}}, field_i, 2'b00};

   generate
      if (BR_ADD_STYLE == 0) begin : g_chain
         assign br_o = seq_o + ofs_bytes;
      end else begin : g_fused
         logic [XLEN-1:0] ofs_plus;
         assign ofs_plus = ofs_bytes + XLEN'(4);
         assign br_o     = pc_i + ofs_plus;
      end
   endgenerate

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
   import pc_nxt_pkg::*;
#(
   parameter int              XLEN         = 32,
   parameter logic [XLEN-1:0] RESET_VEC    = '0,
   parameter int              CMP_STYLE    = 0,
   parameter int              BR_ADD_STYLE = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [XLEN-1:0]    rs_val_i,
   input  logic [XLEN-1:0]    rt_val_i,
   output logic [XLEN-1:0]    pc_o,
   output logic [XLEN-1:0]    link_o,
   output logic               link_we_o,
   output logic               jr_misalign_o
);

   generate
      if (XLEN < INSTR_W) begin : g_bad_xlen
         $error("pc_next_unit: XLEN must be at least 32");
      end
      if (RESET_VEC[1:0] != 2'b00) begin : g_bad_vec
         $error("pc_next_unit: RESET_VEC must be word-aligned");
      end
      if (CMP_STYLE < 0 || CMP_STYLE > 1) begin : g_bad_cmp
         $error("pc_next_unit: CMP_STYLE must be 0 or 1");
      end
      if (BR_ADD_STYLE < 0 || BR_ADD_STYLE > 1) begin : g_bad_add
         $error("pc_next_unit: BR_ADD_STYLE must be 0 or 1");
      end
   endgenerate

   logic [XLEN-1:0] pc_q;
   logic [XLEN-1:0] pc_nxt;
   logic [XLEN-1:0] seq_addr;
   logic [XLEN-1:0] br_addr;
   logic [XLEN-1:0] jmp_addr;
   logic            ops_equal;
   flow_e           flow;

   pc_flow_decode u_dec (
      .opc_i  (instr_i[INSTR_W-1:INSTR_W-OPC_W]),
      .fn_i   (instr_i[FN_W-1:0]),
      .flow_o (flow)
   );

   pc_branch_cmp #(
      .XLEN      (XLEN),
      .CMP_STYLE (CMP_STYLE)
   ) u_cmp (
      .a_i  (rs_val_i),
      .b_i  (rt_val_i),
      .eq_o (ops_equal)
   );

   pc_target_gen #(
      .XLEN         (XLEN),
      .BR_ADD_STYLE (BR_ADD_STYLE)
   ) u_tgt (
      .pc_i    (pc_q),
      .field_i (instr_i[TGT_W-1:0]),
      .seq_o   (seq_addr),
      .br_o    (br_addr),
      .jmp_o   (jmp_addr)
   );

   always_comb begin
      case (flow)
         FLOW_BEQ:          pc_nxt = ops_equal ? br_addr : seq_addr;
         FLOW_BNE:          pc_nxt = ops_equal ? seq_addr : br_addr;
         FLOW_JMP,
         FLOW_JAL:          pc_nxt = jmp_addr;
         FLOW_JREG:         pc_nxt = rs_val_i;
         default:           pc_nxt = seq_addr;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) pc_q <= RESET_VEC;
      else     pc_q <= pc_nxt;
   end

   assign pc_o          = pc_q;
   assign link_o        = seq_addr;
   assign link_we_o     = (flow == FLOW_JAL);
   assign jr_misalign_o = (flow == FLOW_JREG) && (rs_val_i[1:0] != 2'b00);

endmodule

// File: rtl/pc_next_chk.sv
module pc_next_chk #(
   parameter int              XLEN      = 32,
   parameter logic [XLEN-1:0] RESET_VEC = '0
) (
   input logic            clk,
   input logic            rst,
   input logic [31:0]     instr_i,
   input logic [XLEN-1:0] rs_val_i,
   input logic [XLEN-1:0] rt_val_i,
   input logic [XLEN-1:0] pc_o,
   input logic [XLEN-1:0] link_o,
   input logic            link_we_o,
   input logic            jr_misalign_o
);

   logic [5:0]      opc;
   logic            is_jr;
   logic            is_plain;
   logic [XLEN-1:0] ofs_b;

   assign opc      = instr_i[31:26];
   assign is_jr    = (opc == 6'd0) && (instr_i[5:0] == 6'h08);
   assign is_plain = !is_jr && !(opc inside {6'd2, 6'd3, 6'd4, 6'd5});
   assign ofs_b    = {{(XLEN-18){instr_i[15]}}, instr_i[15:0], 2'b00};

   AST_RESET_LOAD: assert property (@(posedge clk)
      rst |=> (pc_o == RESET_VEC)); // R1

   AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      is_plain |=> (pc_o == $past(pc_o) + XLEN'(4))); // R2

   AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (opc == 6'd4 && rs_val_i == rt_val_i) |=> (pc_o == $past(pc_o) + XLEN'(4) + $past(ofs_b))); // R3

   AST_BNE_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (opc == 6'd5 && rs_val_i != rt_val_i) |=> (pc_o == $past(pc_o) + XLEN'(4) + $past(ofs_b))); // R4

   AST_BR_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
      ((opc == 6'd4 && rs_val_i != rt_val_i) || (opc == 6'd5 && rs_val_i == rt_val_i))
      |=> (pc_o == $past(pc_o) + XLEN'(4))); // R5

   AST_JUMP_SPLICE: assert property (@(posedge clk) disable iff (rst)
      (opc == 6'd2 || opc == 6'd3) |=>
      (pc_o[XLEN-5:0] == {$past(instr_i[25:0]), 2'b00}) && (pc_o[XLEN-1:XLEN-4] == $past(pc_o[XLEN-1:XLEN-4]))); // R7

   AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst)
      link_we_o |-> (link_o == pc_o + XLEN'(4)) && (opc == 6'd3)); // R8

   AST_JREG_LOAD: assert property (@(posedge clk) disable iff (rst)
      is_jr |=> (pc_o == $past(rs_val_i))); // R9

   AST_MISALIGN_LOAD: assert property (@(posedge clk) disable iff (rst)
      jr_misalign_o |=> (pc_o[1:0] != 2'b00)); // R10

endmodule

bind pc_next_unit pc_next_chk #(
   .XLEN      (XLEN),
   .RESET_VEC (RESET_VEC)
) u_chk (
   .clk           (clk),
   .rst           (rst),
   .instr_i       (instr_i),
   .rs_val_i      (rs_val_i),
   .rt_val_i      (rt_val_i),
   .pc_o          (pc_o),
   .link_o        (link_o),
   .link_we_o     (link_we_o),
   .jr_misalign_o (jr_misalign_o)
);

// File: tb/pc_next_unit_tb.sv
`timescale 1ns/1ps
module pc_next_unit_tb;

   localparam logic [31:0] RV = 32'h0040_0000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = '0;
   logic [31:0] rs_v = '0;
   logic [31:0] rt_v = '0;
   logic [31:0] pc_o, link_o;
   logic        link_we_o, jr_misalign_o;

   int          checks = 0;
   int          errors = 0;
   bit          done = 0;
   logic [31:0] pc_m;

   always #2.5 clk = ~clk;

   pc_next_unit #(
      .XLEN      (32),
      .RESET_VEC (RV)
   ) u_dut (
      .clk           (clk),
      .rst           (rst),
      .instr_i       (instr),
      .rs_val_i      (rs_v),
      .rt_val_i      (rt_v),
      .pc_o          (pc_o),
      .link_o        (link_o),
      .link_we_o     (link_we_o),
      .jr_misalign_o (jr_misalign_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] sext_ofs(input logic [15:0] imm);
      int signed v;
      v = int'(signed'(imm));
      return 32'(v * 4);
   endfunction

   function automatic string tag_of(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
      logic [5:0] op;
      op = w[31:26];
      if (op == 6'd4) return (a == b) ? "R3" : "R5";
      if (op == 6'd5) return (a != b) ? "R4" : "R5";
      if (op == 6'd2) return "R7";
      if (op == 6'd3) return "R8";
      if (op == 6'd0) return (w[5:0] == 6'h08) ? "R9" : "R11";
      return "R2";
   endfunction

   function automatic logic [31:0] model_next(input logic [31:0] pc, input logic [31:0] w,
                                              input logic [31:0] a, input logic [31:0] b);
      logic [5:0] op;
      op = w[31:26];
      if (op == 6'd4 && a == b) return pc + 32'd4 + sext_ofs(w[15:0]);
      if (op == 6'd5 && a != b) return pc + 32'd4 + sext_ofs(w[15:0]);
      if (op == 6'd2 || op == 6'd3) return {pc[31:28], w[25:0], 2'b00};
      if (op == 6'd0 && w[5:0] == 6'h08) return a;
      return pc + 32'd4;
   endfunction

   // Called just after a falling edge: drive, check combinational outputs,
   // then check the PC after the following rising edge.
   task automatic step(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
      logic [31:0] exp_pc;
      bit          jr;
      instr = w; rs_v = a; rt_v = b;
      #1;
      jr = (w[31:26] == 6'd0) && (w[5:0] == 6'h08);
      chk("R8 link address", link_o, pc_m + 32'd4);
      chk("R8 link strobe", {31'd0, link_we_o}, {31'd0, w[31:26] == 6'd3});
      chk("R10 misalign flag", {31'd0, jr_misalign_o}, {31'd0, jr && (a[1:0] != 2'b00)});
      exp_pc = model_next(pc_m, w, a, b);
      @(posedge clk);
      @(negedge clk);
      chk(tag_of(w, a, b), pc_o, exp_pc);
      pc_m = exp_pc;
   endtask

   task automatic do_reset();
      rst = 1'b1; instr = '0;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk("R1 reset vector", pc_o, RV);
      pc_m = RV;
   endtask

   localparam logic [31:0] JR_W = {6'd0, 20'd0, 6'h08};

   initial begin
      logic [15:0] imms [0:7];
      imms[0] = 16'h0000; imms[1] = 16'h0001; imms[2] = 16'h0003; imms[3] = 16'h7FFF;
      imms[4] = 16'h8000; imms[5] = 16'hFFFF; imms[6] = 16'hFFFE; imms[7] = 16'h1234;

      @(negedge clk);
      do_reset();

      // every opcode, equal and unequal operands (R2 R3 R4 R5 R7 R8)
      for (int op = 0; op < 64; op++) begin
         step({6'(op), 26'h0ABCDE5}, 32'h0000_0010, 32'h0000_0010);
         step({6'(op), 26'h0123420}, 32'h0000_0010, 32'h0000_0024);
      end

      // every function field under opcode 0 (R9 R11)
      for (int f = 0; f < 64; f++) begin
         step({6'd0, 20'hFFFFF, 6'(f)}, 32'h1000_0000 + 32'(f * 4), 32'h0);
      end

      // branch offsets across the signed range (R6)
      for (int k = 0; k < 24; k++) begin
         logic [15:0] imm;
         imm = (k < 8) ? imms[k] : 16'(k * 16'h0B11);
         step(JR_W, 32'h2000_0000, 32'h0);
         step({6'd4, 5'd9, 5'd0, imm}, 32'h5, 32'h5);
         step(JR_W, 32'h2000_0000, 32'h0);
         step({6'd5, 5'd9, 5'd0, imm}, 32'h5, 32'h6);
      end

      // explicit range ends from base 0x20000000 (R6)
      step(JR_W, 32'h2000_0000, 32'h0);
      step({6'd4, 10'd0, 16'h7FFF}, 32'h1, 32'h1);
      chk("R6 max forward", pc_o, 32'h2002_0000);
      step(JR_W, 32'h2000_0000, 32'h0);
      step({6'd4, 10'd0, 16'h8000}, 32'h1, 32'h1);
      chk("R6 max backward", pc_o, 32'h1FFE_0004);

      // worked encoding: lands 16 bytes ahead (R3)
      step(JR_W, 32'h0000_1000, 32'h0);
      step(32'h1120_0003, 32'h7, 32'h7);
      chk("R3 worked example", pc_o, 32'h0000_1010);

      // jump keeps the region nibble (R7 R8)
      step(JR_W, 32'hA000_1000, 32'h0);
      step({6'd3, 26'h3FF_FFFF}, 32'h0, 32'h0);
      chk("R8 jal target", pc_o, 32'hAFFF_FFFC);
      step({6'd2, 26'h000_0001}, 32'h0, 32'h0);
      chk("R7 jump target", pc_o, 32'hA000_0004);

      // unaligned register targets (R10)
      for (int m = 1; m < 4; m++) begin
         step(JR_W, 32'h1234_5670 | 32'(m), 32'h0);
         chk("R10 unaligned value loaded", pc_o, 32'h1234_5670 | 32'(m));
         step(32'h0, 32'h0, 32'h0);
      end
      step(JR_W, 32'h0000_2000, 32'h0);

      // reset in mid-run (R1)
      step({6'd8, 26'h0}, 32'h0, 32'h0);
      do_reset();
      step({6'd12, 26'h0}, 32'h0, 32'h0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule